// File: doc/BRIEF.md
# Priority Express/Preempt Queue Mapper

This block decides, for each of eight transmit priorities, whether frames of that priority go to the express queue or to the preemptable queue. Software writes an 8-bit mask at any time. The written value is held as a pending mask. Each priority's effective mapping bit then follows its pending bit independently, but only in a clock where that priority has no frames queued. As a result, the frames of one priority are never split across both queues. While the link has not yet verified preemption (or been forced into it), the target of every priority is the express queue. Mask writes made during that time are kept and are applied once preemption becomes usable.

Frame tags arrive on a valid/ready stream and leave on a second stream, which adds the selected queue. The path is combinational. The block applies no back-pressure of its own: `in_ready_o` mirrors `sel_ready_i`. A tag is accepted, and counted as queued for its priority, only in a clock where `in_valid_i` and `sel_ready_i` are both high. The queue storage sits outside the block. It reports each frame that leaves through a plain dequeue strobe carrying the frame's priority. The block keeps one saturating up/down occupancy count per priority from the accepted tags and the dequeue strobes.

Top module: `pq_steer_map`

## Requirements
- R1: After reset, `eff_map_o` and `switch_pend_o` are all zero, so every priority maps to express.
- R2: A tag is steered by the effective bit of its priority in the same clock: `sel_queue_o` is 1 (preemptable) when `eff_map_o[in_prio_i]` is 1, and 0 (express) when it is 0.
- R3: A mask write is captured into the pending mask at the clock edge where `mask_we_i` is high. For an empty priority, with `preempt_ok_i` high, the effective bit takes the new value at the following edge.
- R4: A priority that has frames queued keeps its effective bit. It switches at the first edge at which its count is zero.
- R5: A tag accepted for a priority in a clock blocks that priority's switch at the edge that ends that clock.
- R6: While `preempt_ok_i` is low, the target of every priority is express. Pending bits are kept and are applied, subject to occupancy, once `preempt_ok_i` is high again.
- R7: If a pending bit returns to its effective value before the switch happens, no switch occurs, and `switch_pend_o` for that priority clears.
- R8: `switch_pend_o[p]` is 1 exactly when priority p's target differs from `eff_map_o[p]`.
- R9: `in_ready_o` equals `sel_ready_i`, and `sel_valid_o` equals `in_valid_i`. `sel_prio_o` carries `in_prio_i`. Only a handshake counts as an enqueue.
- R10: An enqueue and a dequeue of the same priority in one clock leave its count unchanged. A dequeue of an empty priority is ignored. The count saturates at 2^CNT_W-1 (63 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mask_we_i | input | 1 | Write strobe for the pending mask |
| mask_wdata_i | input | NPRIO | New mask; bit p = 1 sends priority p to the preemptable queue |
| preempt_ok_i | input | 1 | Preemption is verified or forced |
| in_valid_i | input | 1 | Incoming tag valid |
| in_prio_i | input | PW | Priority of the incoming tag |
| in_ready_o | output | 1 | Incoming tag ready (mirrors sel_ready_i) |
| sel_valid_o | output | 1 | Steered tag valid |
| sel_prio_o | output | PW | Priority of the steered tag |
| sel_queue_o | output | 1 | Selected queue: 1 preemptable, 0 express |
| sel_ready_i | input | 1 | Downstream ready |
| deq_valid_i | input | 1 | A frame left the queues |
| deq_prio_i | input | PW | Priority of the departing frame |
| eff_map_o | output | NPRIO | Effective per-priority mapping |
| switch_pend_o | output | NPRIO | Per-priority switch waiting for its queue to drain |

## Verification
The steering outputs and the stream handshake are combinational, so they are due in the clock where the tag is presented. The bench samples them one nanosecond after driving, well before the next rising edge. A mask write lands in the pending mask at the edge that ends the write clock, and it moves the effective bit no earlier than the edge after that. The effect of a dequeue or of an accepted tag on a switch therefore appears one edge after the clock in which it happened. The bench's reference model advances on exactly these edges and compares `eff_map_o` and `switch_pend_o` in every clock. The directed cases also check the first clock in which a blocked switch becomes visible.

// File: rtl/pq_steer_pkg.sv
package pq_steer_pkg;
  localparam int unsigned PQ_NPRIO = 8;
  localparam int unsigned PQ_CNT_W = 6;

  typedef enum logic {
    PQ_EXPRESS = 1'b0,
    PQ_PREEMPT = 1'b1
  } pq_queue_e;
endpackage

// File: rtl/pq_occ_cnt.sv
module pq_occ_cnt #(
  parameter int unsigned CNT_W = pq_steer_pkg::PQ_CNT_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic empty_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             dec_eff;

  // a departure from an empty priority is meaningless and dropped
  assign dec_eff = dec_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_eff) begin
      if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
    end else if (dec_eff && !inc_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/pq_prio_slice.sv
module pq_prio_slice #(
  parameter int unsigned CNT_W = pq_steer_pkg::PQ_CNT_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enq_i,
  input  logic deq_i,
  input  logic target_i,
  output logic sw_ok_o,
  output logic eff_o
);
  logic empty;

  pq_occ_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (enq_i),
    .dec_i   (deq_i),
    .empty_o (empty)
  );

  // no frame queued and none arriving this clock
  assign sw_ok_o = empty && !enq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      eff_o <= pq_steer_pkg::PQ_EXPRESS;
    else if (sw_ok_o) eff_o <= target_i;
  end
endmodule

// File: rtl/pq_steer_map.sv
module pq_steer_map #(
  parameter int unsigned NPRIO = pq_steer_pkg::PQ_NPRIO,
  parameter int unsigned CNT_W = pq_steer_pkg::PQ_CNT_W,
  localparam int unsigned PW   = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [NPRIO-1:0] mask_wdata_i,
  input  logic             preempt_ok_i,
  input  logic             in_valid_i,
  input  logic [PW-1:0]    in_prio_i,
  output logic             in_ready_o,
  output logic             sel_valid_o,
  output logic [PW-1:0]    sel_prio_o,
  output logic             sel_queue_o,
  input  logic             sel_ready_i,
  input  logic             deq_valid_i,
  input  logic [PW-1:0]    deq_prio_i,
  output logic [NPRIO-1:0] eff_map_o,
  output logic [NPRIO-1:0] switch_pend_o
);
  logic [NPRIO-1:0] pend_q;
  logic [NPRIO-1:0] target;
  logic [NPRIO-1:0] sw_ok;
  logic             accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= '0;
    else if (mask_we_i) pend_q <= mask_wdata_i;
  end

  // until preemption is usable every priority aims at express
  assign target = pend_q & {NPRIO{preempt_ok_i}};

  assign accept = in_valid_i && sel_ready_i;

  for (genvar p = 0; p < NPRIO; p++) begin : g_prio
    logic enq;
    logic deq;
    assign enq = accept      && (in_prio_i  == PW'(p));
    assign deq = deq_valid_i && (deq_prio_i == PW'(p));

    pq_prio_slice #(.CNT_W(CNT_W)) u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .enq_i    (enq),
      .deq_i    (deq),
      .target_i (target[p]),
      .sw_ok_o  (sw_ok[p]),
      .eff_o    (eff_map_o[p])
    );
  end

  assign in_ready_o    = sel_ready_i;
  assign sel_valid_o   = in_valid_i;
  assign sel_prio_o    = in_prio_i;
  assign sel_queue_o   = (32'(in_prio_i) < NPRIO) ? eff_map_o[in_prio_i] : 1'b0;
  assign switch_pend_o = target ^ eff_map_o;
endmodule

// File: rtl/pq_steer_map_chk.sv
module pq_steer_map_chk #(
  parameter int unsigned NPRIO = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mask_we_i,
  input logic [NPRIO-1:0] mask_wdata_i,
  input logic             preempt_ok_i,
  input logic [NPRIO-1:0] pend_q,
  input logic [NPRIO-1:0] sw_ok,
  input logic [NPRIO-1:0] eff_map_o,
  input logic [NPRIO-1:0] switch_pend_o
);
  // R4
  occupied_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((eff_map_o ^ $past(eff_map_o)) & ~$past(sw_ok)) == '0);

  // R7
  toward_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((eff_map_o ^ $past(eff_map_o)) &
              ~($past(eff_map_o) ^ ($past(pend_q) & {NPRIO{$past(preempt_ok_i)}}))) == '0);

  // R6
  no_preempt_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preempt_ok_i |=> (eff_map_o & ~$past(eff_map_o)) == '0);

  // R3
  mask_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> pend_q == $past(mask_wdata_i));

  // R8
  settled_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (switch_pend_o == '0) && !mask_we_i |=> $stable(eff_map_o));
endmodule

bind pq_steer_map pq_steer_map_chk #(.NPRIO(NPRIO)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mask_we_i     (mask_we_i),
  .mask_wdata_i  (mask_wdata_i),
  .preempt_ok_i  (preempt_ok_i),
  .pend_q        (pend_q),
  .sw_ok         (sw_ok),
  .eff_map_o     (eff_map_o),
  .switch_pend_o (switch_pend_o)
);

// File: tb/pq_steer_map_tb.sv
module pq_steer_map_tb;
  localparam int NP = 8;
  localparam int PW = 3;
  localparam int CMAX = 63;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mask_we = 1'b0;
  logic [NP-1:0] mask_wd = '0;
  logic          ok = 1'b0;
  logic          in_v = 1'b0;
  logic [PW-1:0] in_p = '0;
  logic          in_r;
  logic          sel_v;
  logic [PW-1:0] sel_p;
  logic          sel_q;
  logic          sel_r = 1'b0;
  logic          deq_v = 1'b0;
  logic [PW-1:0] deq_p = '0;
  logic [NP-1:0] eff;
  logic [NP-1:0] spend;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [NP-1:0] m_pend = '0;
  logic [NP-1:0] m_eff = '0;
  int            m_cnt [NP];

  always #2.5 clk = ~clk;

  pq_steer_map u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mask_we_i(mask_we), .mask_wdata_i(mask_wd),
    .preempt_ok_i(ok), .in_valid_i(in_v), .in_prio_i(in_p), .in_ready_o(in_r),
    .sel_valid_o(sel_v), .sel_prio_o(sel_p), .sel_queue_o(sel_q), .sel_ready_i(sel_r),
    .deq_valid_i(deq_v), .deq_prio_i(deq_p), .eff_map_o(eff), .switch_pend_o(spend)
  );

  task automatic check(input bit good, input string tag, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] tgt_of(logic [NP-1:0] pend, logic k);
    return k ? pend : '0;
  endfunction

  // compare every output against the model, then take one edge and advance the model
  task automatic step(input string tag);
    logic [NP-1:0] t;
    #1;
    t = tgt_of(m_pend, ok);
    check(eff === m_eff, {tag, " eff R4"}, eff, m_eff);
    check(spend === (t ^ m_eff), {tag, " pend R8"}, spend, t ^ m_eff);
    check(in_r === sel_r && sel_v === in_v && sel_p === in_p, {tag, " hs R9"},
          {in_r, sel_v, sel_p}, {sel_r, in_v, in_p});
    if (in_v) check(sel_q === m_eff[in_p], {tag, " steer R2"}, sel_q, m_eff[in_p]);
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      bit e, d;
      e = in_v && sel_r && (in_p == PW'(p));
      d = deq_v && (deq_p == PW'(p)) && (m_cnt[p] != 0);
      if (m_cnt[p] == 0 && !e) m_eff[p] = t[p];
      if (e && !d && m_cnt[p] != CMAX) m_cnt[p]++;
      else if (d && !e) m_cnt[p]--;
    end
    if (mask_we) m_pend = mask_wd;
    @(negedge clk);
  endtask

  task automatic idle();
    mask_we = 1'b0; in_v = 1'b0; deq_v = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < NP; p++) m_cnt[p] = 0;
    repeat (3) @(negedge clk);
    #1;
    check(eff === '0 && spend === '0, "reset R1", {eff, spend}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    sel_r = 1'b1; ok = 1'b1;

    // R3: write to empty priorities, eff follows one edge after capture
    mask_we = 1'b1; mask_wd = 8'hA5; step("R3 wr");
    idle(); #1;
    check(eff === 8'h00 && spend === 8'hA5, "R3 captured", {eff, spend}, 16'h00A5);
    step("R3 a");
    #1; check(eff === 8'hA5, "R3 applied", eff, 8'hA5);

    // R4: queue two frames on prio 1, then request it preemptable
    in_v = 1'b1; in_p = 3'd1; step("R4 enq");
    step("R4 enq2");
    in_v = 1'b0; mask_we = 1'b1; mask_wd = 8'hA7; step("R4 wr");
    mask_we = 1'b0; step("R4 wait");
    #1; check(eff[1] === 1'b0 && spend[1] === 1'b1, "R4 held", {eff[1], spend[1]}, 2'b01);
    deq_v = 1'b1; deq_p = 3'd1; step("R4 deq1");
    step("R4 deq2");
    deq_v = 1'b0; #1; check(eff[1] === 1'b0, "R4 not yet", eff[1], 0);
    step("R4 sw");
    #1; check(eff[1] === 1'b1, "R4 switched", eff[1], 1);

    // R5: an arrival on an empty priority blocks its switch that edge
    mask_we = 1'b1; mask_wd = 8'hAF; step("R5 wr");
    mask_we = 1'b0; in_v = 1'b1; in_p = 3'd3; step("R5 enq");
    in_v = 1'b0; #1; check(eff[3] === 1'b0, "R5 blocked", eff[3], 0);
    // R10: enqueue plus dequeue in one clock keeps one frame queued
    in_v = 1'b1; deq_v = 1'b1; deq_p = 3'd3; step("R10 both");
    in_v = 1'b0; deq_v = 1'b0; step("R10 hold");
    #1; check(eff[3] === 1'b0, "R10 still one", eff[3], 0);
    deq_v = 1'b1; step("R10 deq"); deq_v = 1'b0;
    deq_v = 1'b1; deq_p = 3'd6; step("R10 deq empty"); deq_v = 1'b0;
    step("R10 sw");
    #1; check(eff[3] === 1'b1, "R10 switched", eff[3], 1);

    // R7: queue prio 4, request then revert before drain
    in_v = 1'b1; in_p = 3'd4; step("R7 enq"); in_v = 1'b0;
    mask_we = 1'b1; mask_wd = 8'hBF; step("R7 wr");
    mask_wd = 8'hAF; step("R7 revert"); mask_we = 1'b0;
    #1; check(spend[4] === 1'b0, "R7 cleared", spend[4], 0);
    deq_v = 1'b1; deq_p = 3'd4; step("R7 deq"); deq_v = 1'b0;
    step("R7 idle");
    #1; check(eff[4] === 1'b0, "R7 no switch", eff[4], 0);

    // R9: back-pressure, no handshake means no enqueue
    sel_r = 1'b0; mask_we = 1'b1; mask_wd = 8'hEF; in_v = 1'b1; in_p = 3'd6;
    step("R9 bp"); mask_we = 1'b0; in_v = 1'b0; sel_r = 1'b1;
    step("R9 sw");
    #1; check(eff[6] === 1'b1, "R9 no enq counted", eff[6], 1);

    // R6: preemption lost, all empty priorities fall back to express
    ok = 1'b0; step("R6 off");
    #1; check(eff === 8'h00, "R6 express", eff, 0);
    mask_we = 1'b1; mask_wd = 8'h3C; step("R6 wr"); mask_we = 1'b0;
    step("R6 held");
    #1; check(eff === 8'h00, "R6 still express", eff, 0);
    ok = 1'b1; step("R6 on");
    #1; check(eff === 8'h3C, "R6 applied", eff, 8'h3C);

    // R10: saturation on prio 7, then drain exactly the cap
    mask_we = 1'b1; mask_wd = 8'hBC; step("R10 wr"); mask_we = 1'b0;
    in_v = 1'b1; in_p = 3'd7;
    for (int i = 0; i < CMAX + 5; i++) step("R10 fill");
    in_v = 1'b0; deq_v = 1'b1; deq_p = 3'd7;
    for (int i = 0; i < CMAX; i++) step("R10 drain");
    deq_v = 1'b0; step("R10 sat sw");
    #1; check(eff[7] === 1'b1, "R10 saturated", eff[7], 1);

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      int p;
      mask_we = ($urandom_range(0, 15) == 0);
      mask_wd = NP'($urandom);
      if ($urandom_range(0, 63) == 0) ok = ~ok;
      in_v = $urandom_range(0, 2) == 0;
      in_p = PW'($urandom);
      sel_r = $urandom_range(0, 3) != 0;
      p = $urandom_range(0, NP - 1);
      deq_v = (m_cnt[p] != 0) ? ($urandom_range(0, 1) == 0) : ($urandom_range(0, 15) == 0);
      deq_p = PW'(p);
      step("rand");
    end
    idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule